// File: doc/BRIEF.md
# Regulator Power-Good Supervisor

This block decides whether a voltage regulator may report power-good. Each clock it takes a digitized output-voltage code and the nominal setpoint code. A window check marks the output as out of regulation when it leaves a band of roughly ±5 % around the setpoint. The raw out-of-band flag then passes through a deglitch filter, so a brief excursion cannot change the reported state.

On top of the filtered result sits a priority layer of device-state inputs. These are the supply being valid, enable, undervoltage lockout, overvoltage lockout, soft start, hiccup and thermal shutdown. Any one of them forces the power-good line low in the same cycle it is asserted. A blanking control bit can mask the window result while a voltage transition is in progress. This keeps a planned output ramp from pulling power-good low.

The output models an open-drain pin. `pg_pull_low` = 1 means the pin is pulled low and power-good is not reported. `pg_pull_low` = 0 means the pin is released and power-good is reported. The voltage codes are sampled on every clock and are treated as a continuous level. Because of this the block has no sample handshake and never applies back-pressure.

Top module: `pg_supervisor`

## Requirements
- R1: While `rst_n` is low, `pg_pull_low` is 1. Reset leaves the filtered flag in the fault state, so the pin stays pulled low after reset until an in-window level has passed the deglitch filter.
- R2: The raw window flag is set when `vout_code` < floor(`vset_code`·19/20) or `vout_code` > floor(`vset_code`·21/20). A value equal to either limit is in window.
- R3: The filtered flag takes on the raw flag's value only after the raw flag has been sampled with the same value on HOLD_CYC+1 consecutive clock edges. A raw pulse that lasts HOLD_CYC edges or fewer leaves `pg_pull_low` unchanged.
- R4: A window excursion that lasts long enough pulls the pin low HOLD_CYC edges after the first edge that samples it. A return into the window releases the pin after the same delay.
- R5: While `blank_on_dvs` = 1 and `dvs_active` = 1, the filtered fault is ignored. When DVS ends with the filtered flag still in fault, the pin is pulled low in that same cycle.
- R6: With `blank_on_dvs` = 0, a sustained excursion during `dvs_active` = 1 pulls the pin low, exactly as it does outside DVS.
- R7: Any of `enable` = 0, `uvlo` = 1, `ovlo` = 1, `soft_start` = 1, `hiccup` = 1 or `thermal_sd` = 1 makes `pg_pull_low` 1 in the same cycle, with no deglitch delay.
- R8: `supply_ok` = 0 makes `pg_pull_low` 1 in the same cycle.
- R9: `pg_pull_low` is 0 only when no forcing input is active and the filtered flag is clear or blanked.
- R10: Forcing inputs do not disturb the deglitch filter. When the last forcing input clears, the pin at once reflects the filtered state reached meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vout_code | input | VW | Digitized output voltage |
| vset_code | input | VW | Nominal setpoint code |
| supply_ok | input | 1 | Input supply above the minimum for defined behaviour |
| enable | input | 1 | Converter enabled |
| uvlo | input | 1 | Undervoltage lockout active |
| ovlo | input | 1 | Overvoltage lockout active |
| soft_start | input | 1 | Soft start in progress |
| hiccup | input | 1 | Hiccup overcurrent mode active |
| thermal_sd | input | 1 | Thermal shutdown active |
| dvs_active | input | 1 | Output voltage transition in progress |
| blank_on_dvs | input | 1 | Mask the window result during DVS |
| pg_pull_low | output | 1 | 1 = pull the power-good pin low, 0 = release it |

## Verification
The bench probes each window limit one code inside and one code outside. An off-by-one or non-strict comparison would therefore flip the pin at exactly those codes. It applies glitches one edge shorter than the filter threshold and runs of exactly the threshold length. A filter that counts from the wrong edge, or that does not restart on a change, would release or pull the pin one cycle early or late. It also ends a DVS window while a filtered fault is held, and holds a fault behind a forcing input. A design that re-arms the filter on blanking or on forcing would release the pin where it should be pulled low.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;
  // window ratios: lower = 19/20, upper = 21/20 of the setpoint
  localparam int unsigned LO_NUM = 19;
  localparam int unsigned HI_NUM = 21;
  localparam int unsigned RATIO_DEN = 20;

  // forcing reasons, one bit each in the force vector
  typedef enum logic [2:0] {
    FR_NOSUPPLY  = 3'd0,
    FR_DISABLED  = 3'd1,
    FR_UVLO      = 3'd2,
    FR_OVLO      = 3'd3,
    FR_SOFTSTART = 3'd4,
    FR_HICCUP    = 3'd5,
    FR_THERMAL   = 3'd6
  } force_e;

  localparam int unsigned FORCE_COUNT = 7;
endpackage

// File: rtl/pgmon_window.sv
module pgmon_window #(
  parameter int unsigned VW = 12
) (
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vset_code,
  output logic          raw_fault
);
  import pgmon_pkg::*;

  localparam int unsigned PW = VW + $clog2(HI_NUM + 1);

  logic [PW-1:0] set_ext;
  logic [PW-1:0] lo_lim;
  logic [PW-1:0] hi_lim;
  logic [PW-1:0] vout_ext;

  always_comb begin
    set_ext  = PW'(vset_code);
    vout_ext = PW'(vout_code);
    lo_lim   = (set_ext * PW'(LO_NUM)) / PW'(RATIO_DEN);
    hi_lim   = (set_ext * PW'(HI_NUM)) / PW'(RATIO_DEN);
    raw_fault = (vout_ext < lo_lim) || (vout_ext > hi_lim);
  end
endmodule

// File: rtl/pgmon_deglitch.sv
module pgmon_deglitch #(
  parameter int unsigned HOLD_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic filt_out
);
  localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic          raw_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q    <= 1'b1;
      cnt_q    <= '0;
      filt_out <= 1'b1;
    end else if (raw_in != raw_q) begin
      raw_q <= raw_in;
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      filt_out <= raw_q;
    end
  end
endmodule

// File: rtl/pgmon_force.sv
module pgmon_force (
  input  logic supply_ok,
  input  logic enable,
  input  logic uvlo,
  input  logic ovlo,
  input  logic soft_start,
  input  logic hiccup,
  input  logic thermal_sd,
  output logic any_force
);
  import pgmon_pkg::*;

  logic [FORCE_COUNT-1:0] force_vec;

  always_comb begin
    force_vec               = '0;
    force_vec[FR_NOSUPPLY]  = !supply_ok;
    force_vec[FR_DISABLED]  = !enable;
    force_vec[FR_UVLO]      = uvlo;
    force_vec[FR_OVLO]      = ovlo;
    force_vec[FR_SOFTSTART] = soft_start;
    force_vec[FR_HICCUP]    = hiccup;
    force_vec[FR_THERMAL]   = thermal_sd;
    any_force               = |force_vec;
  end
endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor #(
  parameter int unsigned VW       = 12,
  parameter int unsigned HOLD_CYC = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vset_code,
  input  logic          supply_ok,
  input  logic          enable,
  input  logic          uvlo,
  input  logic          ovlo,
  input  logic          soft_start,
  input  logic          hiccup,
  input  logic          thermal_sd,
  input  logic          dvs_active,
  input  logic          blank_on_dvs,
  output logic          pg_pull_low
);
  logic raw_fault;
  logic filt_fault;
  logic any_force;
  logic blanked;

  pgmon_window #(.VW(VW)) win_i (
    .vout_code (vout_code),
    .vset_code (vset_code),
    .raw_fault (raw_fault)
  );

  pgmon_deglitch #(.HOLD_CYC(HOLD_CYC)) dgl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_fault),
    .filt_out (filt_fault)
  );

  pgmon_force frc_i (
    .supply_ok  (supply_ok),
    .enable     (enable),
    .uvlo       (uvlo),
    .ovlo       (ovlo),
    .soft_start (soft_start),
    .hiccup     (hiccup),
    .thermal_sd (thermal_sd),
    .any_force  (any_force)
  );

  always_comb begin
    blanked     = blank_on_dvs && dvs_active;
    pg_pull_low = !rst_n || any_force || (filt_fault && !blanked);
  end
endmodule

// File: rtl/pgmon_checker.sv
module pgmon_checker #(
  parameter int unsigned VW       = 12,
  parameter int unsigned HOLD_CYC = 5000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] vout_code,
  input logic [VW-1:0] vset_code,
  input logic          supply_ok,
  input logic          enable,
  input logic          uvlo,
  input logic          ovlo,
  input logic          soft_start,
  input logic          hiccup,
  input logic          thermal_sd,
  input logic          dvs_active,
  input logic          blank_on_dvs,
  input logic          pg_pull_low,
  input logic          raw_fault,
  input logic          filt_fault
);
  localparam int unsigned RW = $clog2(HOLD_CYC + 1) + 1;

  logic          prev_raw;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_raw <= 1'b1;
      run_q    <= '0;
    end else begin
      prev_raw <= raw_fault;
      if (raw_fault != prev_raw) run_q <= '0;
      else if (run_q < RW'(HOLD_CYC)) run_q <= run_q + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) p_reset_low_r1: assert (pg_pull_low);
  end

  p_setpoint_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_code == vset_code) |-> !raw_fault);

  p_filter_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_fault != $past(filt_fault)) |-> (run_q >= RW'(HOLD_CYC)));

  p_filter_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_fault != $past(filt_fault)) |-> (filt_fault == $past(raw_fault)));

  p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || uvlo || ovlo || soft_start || hiccup || thermal_sd) |-> pg_pull_low);

  p_supply_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> pg_pull_low);

  p_release_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_pull_low |-> (supply_ok && enable && !uvlo && !ovlo && !soft_start &&
                      !hiccup && !thermal_sd &&
                      (!filt_fault || (blank_on_dvs && dvs_active))));
endmodule

bind pg_supervisor pgmon_checker #(.VW(VW), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .vout_code    (vout_code),
  .vset_code    (vset_code),
  .supply_ok    (supply_ok),
  .enable       (enable),
  .uvlo         (uvlo),
  .ovlo         (ovlo),
  .soft_start   (soft_start),
  .hiccup       (hiccup),
  .thermal_sd   (thermal_sd),
  .dvs_active   (dvs_active),
  .blank_on_dvs (blank_on_dvs),
  .pg_pull_low  (pg_pull_low),
  .raw_fault    (raw_fault),
  .filt_fault   (filt_fault)
);

// File: tb/pg_supervisor_tb_top.sv
module pg_supervisor_tb_top;
  localparam int unsigned VW   = 12;
  localparam int unsigned HOLD = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] vout_code = 12'd1000;
  logic [VW-1:0] vset_code = 12'd1000;
  logic supply_ok = 1'b1, enable = 1'b1, uvlo = 1'b0, ovlo = 1'b0;
  logic soft_start = 1'b0, hiccup = 1'b0, thermal_sd = 1'b0;
  logic dvs_active = 1'b0, blank_on_dvs = 1'b0;
  logic pg_pull_low;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  pg_supervisor #(.VW(VW), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .vset_code(vset_code),
    .supply_ok(supply_ok), .enable(enable), .uvlo(uvlo), .ovlo(ovlo),
    .soft_start(soft_start), .hiccup(hiccup), .thermal_sd(thermal_sd),
    .dvs_active(dvs_active), .blank_on_dvs(blank_on_dvs),
    .pg_pull_low(pg_pull_low)
  );

  always #4 clk = ~clk;

  // reference model: run length of the sampled window flag
  int m_last = 1;
  int m_run  = 1;
  int m_filt = 1;

  function automatic int raw_ref();
    int lo, hi;
    lo = (int'(vset_code) * 19) / 20;
    hi = (int'(vset_code) * 21) / 20;
    return (int'(vout_code) < lo || int'(vout_code) > hi) ? 1 : 0;
  endfunction

  function automatic bit exp_pull();
    bit forced;
    forced = !rst_n || !supply_ok || !enable || uvlo || ovlo || soft_start ||
             hiccup || thermal_sd;
    return forced || (m_filt == 1 && !(blank_on_dvs && dvs_active));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last = 1; m_run = 1; m_filt = 1;
    end else begin
      int r;
      r = raw_ref();
      if (r != m_last) begin m_last = r; m_run = 1; end
      else m_run++;
      if (m_run >= HOLD + 1) m_filt = m_last;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pg_pull_low !== exp_pull()) begin
        failures++;
        $display("FAIL %s cycle-compare: pg_pull_low=%b expected=%b at %0t",
                 tag, pg_pull_low, exp_pull(), $time);
      end
    end
  end

  task automatic chk(input string t, input bit exp);
    @(negedge clk);
    checks++;
    if (pg_pull_low !== exp) begin
      failures++;
      $display("FAIL %s directed: pg_pull_low=%b expected=%b at %0t",
               t, pg_pull_low, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset and start in fault
    tag = "R1";
    step(5);
    chk("R1", 1'b1);
    rst_n = 1'b1;
    step(5);
    chk("R1", 1'b1);
    tag = "R9";
    step(30);
    chk("R9", 1'b0);

    // R2: window limits for setpoint 1000 -> 950 and 1050
    tag = "R2";
    vout_code = 12'd950;  step(30); chk("R2", 1'b0);
    vout_code = 12'd949;  step(30); chk("R2", 1'b1);
    vout_code = 12'd1050; step(30); chk("R2", 1'b0);
    vout_code = 12'd1051; step(30); chk("R2", 1'b1);
    vout_code = 12'd1000; step(30); chk("R2", 1'b0);
    vset_code = 12'd333; vout_code = 12'd316; step(30); chk("R2", 1'b0);
    vout_code = 12'd315; step(30); chk("R2", 1'b1);
    vset_code = 12'd1000; vout_code = 12'd1000; step(30);

    // R3: glitches of HOLD edges and shorter are filtered
    tag = "R3";
    vout_code = 12'd900; step(HOLD); vout_code = 12'd1000;
    chk("R3", 1'b0);
    step(30);
    vout_code = 12'd1100; step(5); vout_code = 12'd1000;
    step(30); chk("R3", 1'b0);

    // R4: sustained fault, exact latency both ways
    tag = "R4";
    vout_code = 12'd900;
    step(HOLD); chk("R4", 1'b0);
    step(1);    chk("R4", 1'b1);
    vout_code = 12'd1000;
    step(HOLD); chk("R4", 1'b1);
    step(1);    chk("R4", 1'b0);

    // R5: blanking during DVS, fault appears when DVS ends
    tag = "R5";
    blank_on_dvs = 1'b1; dvs_active = 1'b1; vout_code = 12'd1200;
    step(40); chk("R5", 1'b0);
    dvs_active = 1'b0; chk("R5", 1'b1);
    vout_code = 12'd1000; step(30); chk("R5", 1'b0);

    // R6: no blanking during DVS
    tag = "R6";
    blank_on_dvs = 1'b0; dvs_active = 1'b1; vout_code = 12'd800;
    step(40); chk("R6", 1'b1);
    vout_code = 12'd1000; step(30); chk("R6", 1'b0);
    dvs_active = 1'b0; step(2);

    // R7: each forcing input, same cycle
    tag = "R7";
    enable = 1'b0;     chk("R7", 1'b1); step(2); enable = 1'b1;     chk("R7", 1'b0);
    uvlo = 1'b1;       chk("R7", 1'b1); step(2); uvlo = 1'b0;       chk("R7", 1'b0);
    ovlo = 1'b1;       chk("R7", 1'b1); step(2); ovlo = 1'b0;       chk("R7", 1'b0);
    soft_start = 1'b1; chk("R7", 1'b1); step(2); soft_start = 1'b0; chk("R7", 1'b0);
    hiccup = 1'b1;     chk("R7", 1'b1); step(2); hiccup = 1'b0;     chk("R7", 1'b0);
    thermal_sd = 1'b1; chk("R7", 1'b1); step(2); thermal_sd = 1'b0; chk("R7", 1'b0);
    step(1);

    // R8: supply not valid
    tag = "R8";
    supply_ok = 1'b0; chk("R8", 1'b1); step(3); supply_ok = 1'b1; chk("R8", 1'b0);
    step(1);

    // R10: filter keeps running behind a forcing input
    tag = "R10";
    enable = 1'b0; vout_code = 12'd700; step(40);
    enable = 1'b1; chk("R10", 1'b1);
    vout_code = 12'd1000; step(1);
    thermal_sd = 1'b1; step(40); thermal_sd = 1'b0; chk("R10", 1'b0);

    step(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule